// File: doc/BRIEF.md
# Half-Band Two-Times Interpolator with Image Select and Zero Insertion

This block sits in front of a digital-to-analog converter. Signed 14-bit samples arrive at the input data rate. Each one is expanded into two filtered output samples by a symmetric 43-tap half-band FIR. The filter is built as two polyphase branches. One branch is a plain delay that applies the centre weight of one half. The other branch folds 22 nonzero weights into 11 multiplies.

A response-select bit keeps either the baseband (low-pass) response or the mirrored upper image (high-pass). The high-pass response is formed by negating every weight at an odd distance from the centre. A zero-insertion bit follows each filter output with a zero sample, so the update rate becomes four times the input rate. The two bits give four digital modes.

There is one clock, and it runs at the final output rate. The producer pulses the input strobe once every two clocks without zero insertion, and once every four clocks with it. The mode pins are taken in only while the synchronous reset is high, and that reset also clears the delay line.

Top module: `hbi_interp2x`

## Requirements
- R1: `in_data_i` is captured on a rising clock edge where `in_valid_i` is 1 and `rst` is 0. It enters the newest position of a 22-entry delay line.
- R2: The centre-branch output is the sample captured 10 strobes before the newest one, multiplied by 0.5. It is rounded as in R6. It is never negated.
- R3: With `mode_i[0]`=0, the folded-branch output is round(sum over i=0..10 of C[i]*(x[k-i]+x[k-21+i]) / 2^17). Here x[k] is the newest sample and C is the 18-bit signed coefficient parameter, default set in the package. C[10] is the weight nearest the centre.
- R4: With `mode_i[0]`=1, the folded-branch output is computed from the negated sum of R3, before rounding.
- R5: Output order after each strobe, starting one clock after it. With `mode_i[1]`=0: folded, then centre. With `mode_i[1]`=1: folded, zero, centre, zero. Every slot is a valid output.
- R6: Rounding adds 2^16 and shifts right by 17 with sign. The result saturates to the range -8192..8191 and never wraps.
- R7: `out_valid_o` stays 0 until 22 samples have been captured since reset. The first valid output is the folded slot, one clock after the 22nd strobe.
- R8: `mode_i` is sampled only on edges where `rst` is 1. A change on `mode_i` while `rst` is 0 has no effect on the output.
- R9: While `rst` is 1, `out_valid_o` and `out_data_o` read 0 one clock later.
- R10: If no further strobe arrives, `out_valid_o` falls once the slots of the last sample have been sent: 2 slots without zero insertion, 4 with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the final output rate |
| rst | input | 1 | Synchronous reset, active high; latches `mode_i` |
| mode_i | input | 2 | Bit 0: 1 = high-pass response; bit 1: 1 = zero insertion |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | 14 | Signed input sample |
| out_data_o | output | 14 | Signed output sample |
| out_valid_o | output | 1 | Output slot carries a valid sample |

## Verification
The bench drives input windows whose signs match the weight signs at full scale, both positive and negative. These push the folded sum well past the 14-bit range, so a design that wrapped instead of clamping would produce outputs with flipped signs. Single impulses walk through every tap and expose a misplaced or mirrored weight. The high-pass runs catch a design that negated the centre branch or skipped the negation. The stuffed modes catch a zero placed in the wrong slot. The bench flips the mode pins mid-run without a reset, which exposes a design that reads the mode live. It also counts the exact clock of the first valid output, so an off-by-one fill length is visible.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    localparam int HB_NPAIR = 11;

    // Folded odd-offset weights, Q1.17; index 10 sits next to the centre.
    localparam logic signed [17:0] HB_COEF [HB_NPAIR] = '{
        18'sd180,   -18'sd430,   18'sd800,  -18'sd1300,
        18'sd1950,  -18'sd2800,  18'sd3900, -18'sd5400,
        18'sd7900,  -18'sd13400, 18'sd41450
    };

    typedef enum logic [1:0] {
        SLOT_FOLD   = 2'd0,
        SLOT_ZERO_A = 2'd1,
        SLOT_CTR    = 2'd2,
        SLOT_ZERO_B = 2'd3
    } slot_kind_e;

endpackage

// File: rtl/hbi_delay_line.sv
module hbi_delay_line #(
    parameter int DW    = 14,
    parameter int DEPTH = 22
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shift_i,
    input  logic signed [DW-1:0] din_i,
    output logic signed [DW-1:0] taps_o [DEPTH]
);

    logic signed [DW-1:0] line_d [DEPTH];
    logic signed [DW-1:0] line_q [DEPTH];

    always_comb begin
        line_d = line_q;
        if (shift_i) begin
            line_d[0] = din_i;
            for (int i = 1; i < DEPTH; i++) begin
                line_d[i] = line_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                line_q[i] <= '0;
            end
        end else begin
            line_q <= line_d;
        end
    end

    assign taps_o = line_q;

    // R1: a strobed sample lands in the newest slot
    p_capture_r1: assert property (@(posedge clk) disable iff (rst)
        shift_i |=> (taps_o[0] == $past(din_i)));

endmodule

// File: rtl/hbi_fold_mac.sv
module hbi_fold_mac #(
    parameter int DW    = 14,
    parameter int CW    = 18,
    parameter int NPAIR = 11,
    parameter int AW    = 38,
    parameter logic signed [CW-1:0] COEF [NPAIR] = hbi_pkg::HB_COEF
) (
    input  logic signed [DW-1:0] taps_i [2*NPAIR],
    input  logic                 hp_i,
    output logic signed [AW-1:0] acc_o
);

    localparam int LAST = 2*NPAIR - 1;

    logic signed [AW-1:0] prod_a [NPAIR];
    logic signed [AW-1:0] tot;

    genvar g;
    for (g = 0; g < NPAIR; g++) begin : g_pair
        logic signed [DW:0] psum;
        assign psum = {taps_i[g][DW-1], taps_i[g]}
                    + {taps_i[LAST-g][DW-1], taps_i[LAST-g]};
        assign prod_a[g] = AW'(psum) * AW'(COEF[g]);
    end

    always_comb begin
        tot = '0;
        for (int i = 0; i < NPAIR; i++) begin
            tot = tot + prod_a[i];
        end
    end

    assign acc_o = hp_i ? -tot : tot;

endmodule

// File: rtl/hbi_round_sat.sv
module hbi_round_sat #(
    parameter int AW    = 38,
    parameter int DW    = 14,
    parameter int CFRAC = 17
) (
    input  logic signed [AW-1:0] acc_i,
    output logic signed [DW-1:0] res_o
);

    localparam logic signed [AW-1:0] HALF = AW'(64'sd1 <<< (CFRAC-1));
    localparam logic signed [AW-1:0] MAXV = AW'((64'sd1 <<< (DW-1)) - 64'sd1);
    localparam logic signed [AW-1:0] MINV = AW'(-(64'sd1 <<< (DW-1)));

    logic signed [AW-1:0] shifted;

    always_comb begin
        shifted = (acc_i + HALF) >>> CFRAC;
        if (shifted > MAXV) begin
            res_o = MAXV[DW-1:0];
        end else if (shifted < MINV) begin
            res_o = MINV[DW-1:0];
        end else begin
            res_o = shifted[DW-1:0];
        end
        // R6: a non-negative sum never comes out negative
        p_nowrap_r6: assert (acc_i < 0 || !res_o[DW-1]);
    end

endmodule

// File: rtl/hbi_interp2x.sv
module hbi_interp2x #(
    parameter int DW    = 14,
    parameter int CW    = 18,
    parameter int CFRAC = 17,
    parameter int NTAP  = 43,
    parameter logic signed [CW-1:0] COEF [(NTAP+1)/4] = hbi_pkg::HB_COEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           mode_i,
    input  logic                 in_valid_i,
    input  logic signed [DW-1:0] in_data_i,
    output logic signed [DW-1:0] out_data_o,
    output logic                 out_valid_o
);

    import hbi_pkg::*;

    localparam int NPAIR = (NTAP + 1) / 4;
    localparam int DEPTH = 2 * NPAIR;
    localparam int CTR   = NPAIR - 1;
    localparam int AW    = DW + CW + $clog2(NPAIR) + 2;
    localparam int FW    = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [2:0]           slot;
        logic [FW-1:0]        fill;
        logic                 hp;
        logic                 stuff;
        logic signed [DW-1:0] dout;
        logic                 vld;
    } st_t;

    st_t s_d, s_q;

    logic signed [DW-1:0] taps [DEPTH];
    logic signed [AW-1:0] fold_acc;
    logic signed [AW-1:0] ctr_acc;
    logic signed [DW-1:0] fold_res;
    logic signed [DW-1:0] ctr_res;
    logic [2:0]           nslot;
    slot_kind_e           kind;

    hbi_delay_line #(.DW(DW), .DEPTH(DEPTH)) u_line (
        .clk     (clk),
        .rst     (rst),
        .shift_i (in_valid_i && !rst),
        .din_i   (in_data_i),
        .taps_o  (taps)
    );

    hbi_fold_mac #(.DW(DW), .CW(CW), .NPAIR(NPAIR), .AW(AW), .COEF(COEF)) u_mac (
        .taps_i (taps),
        .hp_i   (s_q.hp),
        .acc_o  (fold_acc)
    );

    assign ctr_acc = AW'(taps[CTR]) <<< (CFRAC - 1);

    hbi_round_sat #(.AW(AW), .DW(DW), .CFRAC(CFRAC)) u_rs_fold (
        .acc_i (fold_acc),
        .res_o (fold_res)
    );

    hbi_round_sat #(.AW(AW), .DW(DW), .CFRAC(CFRAC)) u_rs_ctr (
        .acc_i (ctr_acc),
        .res_o (ctr_res)
    );

    always_comb begin
        nslot = s_q.stuff ? 3'd4 : 3'd2;
        if (s_q.stuff) begin
            kind = slot_kind_e'(s_q.slot[1:0]);
        end else begin
            kind = s_q.slot[0] ? SLOT_CTR : SLOT_FOLD;
        end
    end

    always_comb begin
        s_d = s_q;
        if (rst) begin
            s_d       = '0;
            s_d.hp    = mode_i[0];
            s_d.stuff = mode_i[1];
            s_d.slot  = 3'd4;
        end else begin
            s_d.vld  = (s_q.fill == FW'(DEPTH)) && (s_q.slot < nslot);
            s_d.dout = '0;
            if (s_d.vld) begin
                case (kind)
                    SLOT_FOLD: s_d.dout = fold_res;
                    SLOT_CTR:  s_d.dout = ctr_res;
                    default:   s_d.dout = '0;
                endcase
            end
            if (in_valid_i) begin
                s_d.slot = 3'd0;
            end else if (s_q.slot < nslot) begin
                s_d.slot = s_q.slot + 3'd1;
            end
            if (in_valid_i && (s_q.fill < FW'(DEPTH))) begin
                s_d.fill = s_q.fill + FW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign out_data_o  = s_q.dout;
    assign out_valid_o = s_q.vld;

    // R9: reset clears the output
    p_rst_clear_r9: assert property (@(posedge clk)
        rst |=> (!out_valid_o && out_data_o == '0));

    // R8: mode bits hold while out of reset
    p_mode_hold_r8: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> $stable({s_q.hp, s_q.stuff}));

    // R7: no valid output before the line is full
    p_valid_fill_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> (s_q.fill == FW'(DEPTH)));

    // R5: in stuffed mode a nonzero output is followed by a zero
    p_stuff_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (s_q.stuff && out_valid_o && $past(out_valid_o) && ($past(out_data_o) != '0))
        |-> (out_data_o == '0));

endmodule

// File: tb/tb_hbi_interp2x.sv
`timescale 1ns/1ps
module tb_hbi_interp2x;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        mode = 2'b00;
    logic              in_valid = 1'b0;
    logic signed [13:0] in_data = '0;
    logic signed [13:0] out_data;
    logic              out_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int    cf [11] = '{180, -430, 800, -1300, 1950, -2800, 3900, -5400, 7900, -13400, 41450};
    int    xh [22];
    int    ev [2][4];
    bit    evv [2][4];
    string etag [2][4];
    int    nsamp;
    int    nper;
    bit    hp_b, stuff_b;
    string ptag;

    always #2.5 clk = ~clk;

    hbi_interp2x dut (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode),
        .in_valid_i  (in_valid),
        .in_data_i   (in_data),
        .out_data_o  (out_data),
        .out_valid_o (out_valid)
    );

    function automatic int rnd_sat(longint acc);
        longint r;
        r = (acc + 65536) >>> 17;
        if (r > 8191) r = 8191;
        if (r < -8192) r = -8192;
        return int'(r);
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void build(int b);
        longint acc = 0;
        int fo, ce;
        for (int i = 0; i < 11; i++) acc += longint'(cf[i]) * longint'(xh[i] + xh[21-i]);
        if (hp_b) acc = -acc;
        fo = rnd_sat(acc);
        ce = rnd_sat(longint'(xh[10]) * 65536);
        for (int s = 0; s < 4; s++) evv[b][s] = (nsamp >= 22);
        ev[b][0] = fo;
        etag[b][0] = {ptag, hp_b ? "/R4" : "/R3"};
        if (stuff_b) begin
            ev[b][1] = 0;  etag[b][1] = {ptag, "/R5"};
            ev[b][2] = ce; etag[b][2] = {ptag, "/R2"};
            ev[b][3] = 0;  etag[b][3] = {ptag, "/R5"};
        end else begin
            ev[b][1] = ce; etag[b][1] = {ptag, "/R2"};
        end
    endfunction

    task automatic step(int k, int c, bit drive, int x);
        int j, s;
        @(negedge clk);
        if (c < 2) begin j = k - 1; s = c + nper - 2; end
        else       begin j = k;     s = c - 2;        end
        if (j < 0 || !evv[j%2][s]) begin
            check({ptag, "/R7 valid"}, int'(out_valid), 0);
        end else begin
            check({ptag, "/R7 valid"}, int'(out_valid), 1);
            check(etag[j%2][s], int'(out_data), ev[j%2][s]);
        end
        in_valid = drive;
        in_data  = 14'(x);
        if (drive) begin
            for (int i = 21; i > 0; i--) xh[i] = xh[i-1];
            xh[0] = x;
            nsamp++;
            build(k % 2);
        end
    endtask

    task automatic send(int k, int x);
        for (int c = 0; c < nper; c++) step(k, c, c == 0, x);
    endtask

    task automatic do_reset(logic [1:0] m);
        @(negedge clk);
        mode = m; rst = 1'b1; in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 valid", int'(out_valid), 0);
        check("R9 data", int'(out_data), 0);
        rst = 1'b0;
        hp_b = m[0]; stuff_b = m[1];
        nper = stuff_b ? 4 : 2;
        nsamp = 0;
        for (int i = 0; i < 22; i++) xh[i] = 0;
        for (int b = 0; b < 2; b++) for (int s = 0; s < 4; s++) evv[b][s] = 0;
    endtask

    task automatic flush(int k);
        ptag = "R10";
        for (int c = 0; c < 2; c++) step(k, c, 1'b0, 0);
        repeat (2) begin
            @(negedge clk);
            check("R10 valid drop", int'(out_valid), 0);
        end
    endtask

    function automatic int sat_pat(int n);
        int p, i, sg;
        p  = 21 - (n % 22);
        i  = (p < 11) ? p : 21 - p;
        sg = (cf[i] > 0) ? 1 : -1;
        if ((n / 22) % 2 == 0) return sg * 8191;
        return (sg > 0) ? -8192 : 8191;
    endfunction

    function automatic int rnd_x();
        return int'($urandom_range(16383)) - 8192;
    endfunction

    initial begin
        void'($urandom(32'd24681));

        // run A: baseband, no insertion; then mode pins move without reset
        do_reset(2'b00);
        ptag = "R6";
        for (int k = 0; k < 44; k++) send(k, sat_pat(k));
        ptag = "R1";
        for (int k = 44; k < 100; k++) begin
            if (k == 70) begin mode = 2'b11; ptag = "R8"; end
            send(k, rnd_x());
        end
        flush(100);

        // run B: high-pass, no insertion
        do_reset(2'b01);
        ptag = "R6";
        for (int k = 0; k < 44; k++) send(k, sat_pat(k));
        ptag = "R1";
        for (int k = 44; k < 90; k++) send(k, rnd_x());
        flush(90);

        // run C: baseband with zero insertion, impulses then noise
        do_reset(2'b10);
        ptag = "R3";
        for (int k = 0; k < 56; k++)
            send(k, (k == 5) ? 8191 : ((k == 30) ? -8192 : 0));
        ptag = "R1";
        for (int k = 56; k < 86; k++) send(k, rnd_x());
        flush(86);

        // run D: high-pass with zero insertion
        do_reset(2'b11);
        ptag = "R6";
        for (int k = 0; k < 44; k++) send(k, sat_pat(k));
        ptag = "R1";
        for (int k = 44; k < 90; k++) send(k, rnd_x());
        flush(90);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule